// File: doc/BRIEF.md
# Microsecond Time Base with Compare Alarms

The block keeps a 64-bit count of microseconds since reset. A tick-enable input, pulsed once per microsecond by logic outside the block, advances it, and a pause input can hold it. Software reaches the count through a 32-bit register bus. The count is split into a high half and a low half. Each half is accessed through separate registers, and the order of access keeps each 64-bit access consistent:

- **Setting the time.** Software writes the low-half staging register first. The whole 64-bit value is then loaded by the write to the high-half register.
- **Reading the time.** Reading the low half captures the matching high half. A later read of the high half returns that captured value.

Four alarm channels each hold a 32-bit target. Writing a target arms its channel. On every microsecond step, each armed channel compares its target with the new low half of the time. On a match the channel disarms and sets a sticky interrupt bit, which software clears by writing 1 to it. An enable mask selects which sticky bits drive the single interrupt output. An armed channel can be cancelled before it matches.

All register offsets are in bytes. The bus read data is combinational from the current address.

Top module: `usec_timer`

## Requirements
- R1: After reset the time is 0, no alarm is armed, the sticky interrupt bits (0x24) and the enable bits (0x28) read 0, and `irq` is 0.
- R2: A write to 0x04 only stages a low word and leaves the time unchanged. A write to 0x00 loads the time with {written word, staged low word} at that clock edge.
- R3: On each clock edge where `tick_en`=1 and `pause`=0, the time increases by 1, wrapping from 2^64-1 to 0. Otherwise it holds. A write to 0x00 in the same cycle takes priority over the step.
- R4: While `pause`=1 the time holds even with `tick_en`=1. Armed status bits and sticky interrupt bits are unchanged.
- R5: A read of 0x0C returns the low 32 bits of the time and captures the high 32 bits. Reads of 0x08 return the captured word, which does not follow counting until the next 0x0C read.
- R6: A write to 0x10+4n (n=0..3) stores target n, readable at the same offset, and sets bit n of the status register 0x20.
- R7: When a step makes the low 32 bits of the time equal the target of armed channel n, bit n of 0x24 becomes 1 and bit n of 0x20 becomes 0 at that same edge. A disarmed channel never fires again.
- R8: Writing 1 to bit n of 0x20 disarms channel n, and the channel then does not fire. Writing 0 bits has no effect. A cancel in the cycle of a match wins, and no interrupt bit is set.
- R9: Writing 1 to bit n of 0x24 clears it, and writing 0 has no effect. If channel n fires in the same cycle as its clear, the bit ends up 1.
- R10: Bits 3:0 of 0x28 are read/write enables. 0x2C reads (0x24 AND 0x28), and `irq` is 1 exactly when that value is nonzero.
- R11: A write to channel n's target in the cycle where its old target matches loads the new target. The channel stays armed and no interrupt bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle pulse per microsecond |
| pause | input | 1 | Holds the time while 1 |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| irq | output | 1 | OR of enabled sticky interrupt bits |

## Verification
Two events can fall in the same clock cycle: an alarm match, and a bus write that either clears that channel's sticky bit or cancels or re-targets that channel. The bench raises `tick_en` while issuing the write, so that the step onto the target and the write share one edge. It then reads the status and sticky registers and checks them against the stated winner of each collision. The pause-versus-tick and time-load-versus-tick collisions are provoked and judged the same way.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
    localparam logic [5:0] OFS_WR_HI   = 6'h00;
    localparam logic [5:0] OFS_WR_LO   = 6'h04;
    localparam logic [5:0] OFS_RD_HI   = 6'h08;
    localparam logic [5:0] OFS_RD_LO   = 6'h0C;
    localparam logic [5:0] OFS_ALARM0  = 6'h10;
    localparam logic [5:0] OFS_STATUS  = 6'h20;
    localparam logic [5:0] OFS_RAW     = 6'h24;
    localparam logic [5:0] OFS_INTEN   = 6'h28;
    localparam logic [5:0] OFS_MASKED  = 6'h2C;
endpackage

// File: rtl/utm_counter.sv
module utm_counter #(
    parameter int unsigned BUS_W  = 32,
    parameter int unsigned TIME_W = 2 * BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              pause,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              rd_lo,
    input  logic [BUS_W-1:0]  wdata,
    output logic [TIME_W-1:0] now_q,
    output logic [BUS_W-1:0]  now_lo_next,
    output logic [BUS_W-1:0]  hi_latch_q,
    output logic              step
);
    localparam int unsigned HI_W = TIME_W - BUS_W;

    typedef struct packed {
        logic [TIME_W-1:0] now;
        logic [BUS_W-1:0]  lo_stage;
        logic [HI_W-1:0]   hi_latch;
    } cnt_t;

    cnt_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        step = tick_en & ~pause & ~wr_hi;
        if (wr_lo)
            s_d.lo_stage = wdata;
        if (wr_hi)
            s_d.now = {wdata[HI_W-1:0], s_q.lo_stage};
        else if (step)
            s_d.now = s_q.now + 1'b1;
        if (rd_lo)
            s_d.hi_latch = s_q.now[TIME_W-1:BUS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign now_q       = s_q.now;
    assign now_lo_next = s_d.now[BUS_W-1:0];
    assign hi_latch_q  = BUS_W'(s_q.hi_latch);

    // R3
    step_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !pause && !wr_hi) |=> now_q == $past(now_q) + 1'b1);
    // R4
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !wr_hi) |=> $stable(now_q));
    // R2
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hi && !wr_lo) |=> now_q[TIME_W-1:BUS_W] == $past(wdata[HI_W-1:0]));
    // R5
    latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> hi_latch_q == $past(now_q[TIME_W-1:BUS_W]));
endmodule

// File: rtl/utm_alarm.sv
module utm_alarm #(
    parameter int unsigned BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [BUS_W-1:0] now_lo_next,
    input  logic             arm_wr,
    input  logic             cancel,
    input  logic [BUS_W-1:0] wdata,
    output logic             armed_q,
    output logic [BUS_W-1:0] target_q,
    output logic             fire
);
    typedef struct packed {
        logic             armed;
        logic [BUS_W-1:0] target;
    } alm_t;

    alm_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        fire = step & s_q.armed & ~arm_wr & ~cancel & (now_lo_next == s_q.target);
        if (arm_wr) begin
            s_d.target = wdata;
            s_d.armed  = 1'b1;
        end else if (cancel || fire) begin
            s_d.armed  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign armed_q  = s_q.armed;
    assign target_q = s_q.target;

    // R7
    fire_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !armed_q);
    // R6
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_wr |=> (armed_q && target_q == $past(wdata)));
    // R8
    cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cancel && !arm_wr) |=> !armed_q);
endmodule

// File: rtl/usec_timer.sv
module usec_timer
    import usec_timer_pkg::*;
#(
    parameter int unsigned NUM_ALARMS = 4,
    parameter int unsigned BUS_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             pause,
    input  logic             bus_en,
    input  logic             bus_we,
    input  logic [5:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    output logic             irq
);
    localparam int unsigned TIME_W = 2 * BUS_W;

    typedef struct packed {
        logic [NUM_ALARMS-1:0] raw;
        logic [NUM_ALARMS-1:0] inten;
    } top_t;

    top_t s_d, s_q;

    logic                  wr, rd;
    logic [TIME_W-1:0]     now;
    logic [BUS_W-1:0]      now_lo_next, hi_latch;
    logic                  step;
    logic [NUM_ALARMS-1:0] alarm_hit, armed, fire;
    logic [BUS_W-1:0]      target [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] masked;

    assign wr = bus_en & bus_we;
    assign rd = bus_en & ~bus_we;

    utm_counter #(.BUS_W(BUS_W), .TIME_W(TIME_W)) u_counter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_en     (tick_en),
        .pause       (pause),
        .wr_lo       (wr && bus_addr == OFS_WR_LO),
        .wr_hi       (wr && bus_addr == OFS_WR_HI),
        .rd_lo       (rd && bus_addr == OFS_RD_LO),
        .wdata       (bus_wdata),
        .now_q       (now),
        .now_lo_next (now_lo_next),
        .hi_latch_q  (hi_latch),
        .step        (step)
    );

    for (genvar n = 0; n < NUM_ALARMS; n++) begin : g_alarm
        assign alarm_hit[n] = (bus_addr == OFS_ALARM0 + 6'(4 * n));
        utm_alarm #(.BUS_W(BUS_W)) u_alarm (
            .clk         (clk),
            .rst_n       (rst_n),
            .step        (step),
            .now_lo_next (now_lo_next),
            .arm_wr      (wr && alarm_hit[n]),
            .cancel      (wr && bus_addr == OFS_STATUS && bus_wdata[n]),
            .wdata       (bus_wdata),
            .armed_q     (armed[n]),
            .target_q    (target[n]),
            .fire        (fire[n])
        );

        // R9
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[n] |=> s_q.raw[n]);
        // R9
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && bus_addr == OFS_RAW && bus_wdata[n] && !fire[n]) |=> !s_q.raw[n]);
    end

    always_comb begin
        s_d     = s_q;
        s_d.raw = s_q.raw;
        if (wr && bus_addr == OFS_RAW)
            s_d.raw = s_q.raw & ~bus_wdata[NUM_ALARMS-1:0];
        s_d.raw = s_d.raw | fire;
        if (wr && bus_addr == OFS_INTEN)
            s_d.inten = bus_wdata[NUM_ALARMS-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign masked = s_q.raw & s_q.inten;
    assign irq    = |masked;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_RD_LO:  bus_rdata = now[BUS_W-1:0];
            OFS_RD_HI:  bus_rdata = hi_latch;
            OFS_STATUS: bus_rdata = BUS_W'(armed);
            OFS_RAW:    bus_rdata = BUS_W'(s_q.raw);
            OFS_INTEN:  bus_rdata = BUS_W'(s_q.inten);
            OFS_MASKED: bus_rdata = BUS_W'(masked);
            default:    bus_rdata = '0;
        endcase
        for (int n = 0; n < NUM_ALARMS; n++)
            if (alarm_hit[n]) bus_rdata = target[n];
    end

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.inten == '0) |-> !irq);
    // R4
    pause_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pause && !bus_en) |=> ($stable(armed) && $stable(s_q.raw)));
endmodule

// File: tb/usec_timer_bench.sv
module usec_timer_bench;
    logic        clk = 0, rst_n = 0, tick_en = 0, pause = 0;
    logic        bus_en = 0, bus_we = 0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic        irq;
    int          total = 0, bad = 0;
    logic [31:0] v;

    always #2 clk = ~clk;

    usec_timer u_usec_timer (.*);

    typedef struct packed {
        logic [31:0] hi, lo, ticks, exp_hi, exp_lo;
    } vec_t;

    localparam vec_t VEC [5] = '{
        '{32'h0,        32'h0,        32'd5,  32'h0,        32'h5},
        '{32'h1,        32'hFFFF_FFFE, 32'd3, 32'h2,        32'h1},
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd1, 32'h0,       32'h0},
        '{32'h1234_5678, 32'h9ABC_DEF0, 32'd0, 32'h1234_5678, 32'h9ABC_DEF0},
        '{32'h0,        32'hFF,       32'd16, 32'h0,        32'h10F}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_en = 1; bus_we = 0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_en = 0;
    endtask

    task automatic step(input int n);
        if (n > 0) begin
            tick_en = 1;
            repeat (n) @(posedge clk);
            #1 tick_en = 0;
        end
    endtask

    task automatic set_time(input logic [31:0] hi, input logic [31:0] lo);
        wr(6'h04, lo);
        wr(6'h00, hi);
    endtask

    initial begin
        #800000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        rd(6'h0C, v); chk("R1 time lo", v, 0);
        rd(6'h08, v); chk("R1 time hi", v, 0);
        rd(6'h20, v); chk("R1 status", v, 0);
        rd(6'h24, v); chk("R1 raw", v, 0);
        rd(6'h28, v); chk("R1 inten", v, 0);
        chk("R1 irq", {31'b0, irq}, 0);

        // R2 R3 vector table
        for (int i = 0; i < 5; i++) begin
            set_time(VEC[i].hi, VEC[i].lo);
            step(VEC[i].ticks);
            rd(6'h0C, v); chk("R3 vec lo", v, VEC[i].exp_lo);
            rd(6'h08, v); chk("R3 vec hi", v, VEC[i].exp_hi);
        end

        // R2 staging alone does not change time
        set_time(32'h5, 32'h50);
        wr(6'h04, 32'hDEAD);
        rd(6'h0C, v); chk("R2 stage only", v, 32'h50);

        // R3 load wins over step
        wr(6'h04, 32'h77);
        tick_en = 1; wr(6'h00, 32'h3); tick_en = 0;
        rd(6'h0C, v); chk("R3 load priority lo", v, 32'h77);
        rd(6'h08, v); chk("R3 load priority hi", v, 32'h3);

        // R5 latched high half
        set_time(32'h7, 32'hFFFF_FFFF);
        rd(6'h0C, v); chk("R5 lo", v, 32'hFFFF_FFFF);
        step(2);
        rd(6'h08, v); chk("R5 latched hi", v, 32'h7);
        rd(6'h0C, v); chk("R5 lo after", v, 32'h1);
        rd(6'h08, v); chk("R5 relatched hi", v, 32'h8);

        // R6 R7 arm and fire
        set_time(32'h0, 32'h0);
        wr(6'h10, 32'h3);
        rd(6'h20, v); chk("R6 armed", v, 32'h1);
        rd(6'h10, v); chk("R6 target", v, 32'h3);
        step(2);
        rd(6'h24, v); chk("R7 not yet", v, 0);
        step(1);
        rd(6'h24, v); chk("R7 fired", v, 32'h1);
        rd(6'h20, v); chk("R7 disarmed", v, 0);

        // R10 enable and masked
        wr(6'h28, 32'h1);
        rd(6'h2C, v); chk("R10 masked", v, 32'h1);
        chk("R10 irq on", {31'b0, irq}, 1);
        wr(6'h28, 32'h0);
        rd(6'h2C, v); chk("R10 masked off", v, 0);
        chk("R10 irq off", {31'b0, irq}, 0);
        wr(6'h28, 32'hF);

        // R9 write-1-to-clear
        wr(6'h24, 32'h0);
        rd(6'h24, v); chk("R9 zero write", v, 32'h1);
        wr(6'h24, 32'h1);
        rd(6'h24, v); chk("R9 cleared", v, 0);
        chk("R9 irq clear", {31'b0, irq}, 0);

        // R7 fires once only
        set_time(32'h0, 32'h0);
        step(4);
        rd(6'h24, v); chk("R7 once", v, 0);

        // R4 pause
        set_time(32'h0, 32'h100);
        wr(6'h14, 32'h102);
        pause = 1; step(5); pause = 0;
        rd(6'h0C, v); chk("R4 paused time", v, 32'h100);
        rd(6'h20, v); chk("R4 armed kept", v, 32'h2);
        rd(6'h24, v); chk("R4 raw kept", v, 0);
        step(2);
        rd(6'h24, v); chk("R7 after pause", v, 32'h2);
        wr(6'h24, 32'hF);

        // R9 fire in same cycle as clear
        set_time(32'h0, 32'h0);
        wr(6'h14, 32'h1);
        tick_en = 1; wr(6'h24, 32'h2); tick_en = 0;
        rd(6'h24, v); chk("R9 set wins", v, 32'h2);
        wr(6'h24, 32'hF);

        // R8 cancel
        set_time(32'h0, 32'h0);
        wr(6'h18, 32'h5);
        wr(6'h20, 32'h0);
        rd(6'h20, v); chk("R8 zero no effect", v, 32'h4);
        wr(6'h20, 32'h4);
        rd(6'h20, v); chk("R8 cancelled", v, 0);
        step(6);
        rd(6'h24, v); chk("R8 no fire", v, 0);
        set_time(32'h0, 32'h0);
        wr(6'h18, 32'h1);
        tick_en = 1; wr(6'h20, 32'h4); tick_en = 0;
        rd(6'h24, v); chk("R8 cancel wins", v, 0);
        rd(6'h20, v); chk("R8 cancel wins status", v, 0);

        // R11 retarget in match cycle
        set_time(32'h0, 32'h0);
        wr(6'h1C, 32'h1);
        tick_en = 1; wr(6'h1C, 32'hA); tick_en = 0;
        rd(6'h20, v); chk("R11 still armed", v, 32'h8);
        rd(6'h24, v); chk("R11 no irq", v, 0);
        step(9);
        rd(6'h24, v); chk("R11 new target fired", v, 32'h8);
        chk("R10 irq from ch3", {31'b0, irq}, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule